// File: doc/BRIEF.md
# Bus-Master Memory Strobe Timer

This block produces the memory read and memory write command strobes for a bus-master DMA engine that drives an asynchronous, ISA-style memory bus. It runs only from the card's own clock, nominally 20 MHz, so every phase is a whole number of 50 ns clock periods. The bus clock plays no part in the timing. A client presents one transfer at a time: an address, a direction, write data and an 8-bit speed code. The block then runs one beat. The command strobe is held active for a pulse count and then inactive for a recovery count. Both counts are looked up from the speed code.

Speed codes below 128 select fixed standard timings, and code 255 selects the slowest setting. Codes 128 to 254 are custom codes in which the pulse and recovery counts are written straight into the code, each in 50 ns units. The target may hold the ready line low to stretch the pulse. Read data is captured on the clock edge that ends the pulse. A one-cycle done pulse marks the last clock of recovery. A request offered in that same cycle starts the next pulse on the next edge, so beats can run back to back at the exact programmed cycle time.

Top module: `mst_strobe_timer`

## Requirements
- R1: While reset is held, and after its release until a request arrives, `memr_n` and `memw_n` are high, `done` is low and `req_ready` is high.
- R2: A beat with `req_write`=1 drives only `memw_n` low, and a read beat drives only `memr_n` low. The two strobes are never low together. `bus_addr` and `bus_wdata` hold the accepted values throughout the pulse.
- R3: The standard codes give these pulse/recovery lengths in clocks: code 0 → 5/3, code 1 → 3/3, code 2 → 2/3, code 3 → 2/2, code 4 → 4/3. The pulse begins on the first clock edge after the edge that accepts the request.
- R4: Code 255 (0xFF) gives a 9-clock pulse and a 3-clock recovery.
- R5: Codes 128–254 (bit 7 set) are custom. Bits [6:3] give the pulse length in clocks and bits [2:0] give the recovery length in clocks. For example, 0xA2 gives 4/2 (200 ns / 100 ns) and 0xB5 gives 6/5.
- R6: A custom field below 2 is raised to 2, so neither phase of any code is ever shorter than 2 clocks.
- R7: Undefined standard codes (5 to 127) use the code-0 timing of 5/3.
- R8: When `mem_ready` is low on the clock edge that would end the pulse, the pulse continues. It ends on the first edge at which `mem_ready` is high. A low `mem_ready` earlier in the pulse has no effect.
- R9: On a read beat, `rd_data` takes the value of `bus_rdata` present on the edge that ends the pulse. It keeps that value until the next read beat, whatever `bus_rdata` does afterwards.
- R10: `done` is high for exactly one clock, the last clock of recovery, and `req_ready` is high in that same clock. A request accepted there starts its pulse on the next edge, so the time between two back-to-back pulses equals the recovery count.
- R11: A `req_valid` offered while a beat is in progress is ignored. The strobe direction and `bus_addr` of the running beat stay unchanged, and no extra beat follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Card clock (nominally 20 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transfer request |
| req_write | input | 1 | 1 = memory write, 0 = memory read |
| req_addr | input | AW | Beat address |
| req_wdata | input | DW | Write data |
| speed_code | input | 8 | Timing code, sampled with the request |
| req_ready | output | 1 | High when a request can be accepted |
| mem_ready | input | 1 | Target ready; low stretches the pulse |
| bus_rdata | input | DW | Data driven by memory on reads |
| memr_n | output | 1 | Active-low memory read strobe |
| memw_n | output | 1 | Active-low memory write strobe |
| bus_addr | output | AW | Address of the current beat |
| bus_wdata | output | DW | Write data of the current beat |
| rd_data | output | DW | Captured read data |
| done | output | 1 | One-cycle pulse in the last recovery clock |

## Verification
Two events can land in the same clock: the done pulse that closes recovery, and the acceptance of the next request. A second event can also meet the last count of the pulse: the release of the wait line. The bench provokes the first pair by holding `req_valid` high through a run of code-3 beats. It then measures the strobe low/high/low run lengths and requires `done` and `req_ready` together in the final recovery clock, with the pulse-to-pulse gap exactly equal to the recovery count. It provokes the second pair by releasing `mem_ready` on the cycle the pulse count expires, and again earlier, inside the counted pulse. The measured pulse width and the captured read data must show the pulse ending on the release edge in the first case and unchanged in the second.

// File: rtl/mst_pkg.sv
package mst_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ACT  = 2'd1,
    PH_REC  = 2'd2
  } phase_e;

  localparam int unsigned CODE_W   = 8;
  localparam int unsigned MIN_CLKS = 2;
endpackage

// File: rtl/mst_speed_decode.sv
module mst_speed_decode
  import mst_pkg::*;
#(
  parameter int unsigned CW = 4
) (
  input  logic [CODE_W-1:0] code,
  output logic [CW-1:0]     act_clks,
  output logic [CW-1:0]     rec_clks
);
  localparam logic [CW-1:0] FLOOR = CW'(MIN_CLKS);

  function automatic logic [CW-1:0] floor2(input logic [CW-1:0] v);
    return (v < FLOOR) ? FLOOR : v;
  endfunction

  always_comb begin
    act_clks = CW'(5);
    rec_clks = CW'(3);
    if (code == 8'hFF) begin
      act_clks = CW'(9);
      rec_clks = CW'(3);
    end else if (code[7]) begin
      act_clks = floor2(CW'(code[6:3]));
      rec_clks = floor2(CW'(code[2:0]));
    end else begin
      case (code[6:0])
        7'd0:    begin act_clks = CW'(5); rec_clks = CW'(3); end
        7'd1:    begin act_clks = CW'(3); rec_clks = CW'(3); end
        7'd2:    begin act_clks = CW'(2); rec_clks = CW'(3); end
        7'd3:    begin act_clks = CW'(2); rec_clks = CW'(2); end
        7'd4:    begin act_clks = CW'(4); rec_clks = CW'(3); end
        default: begin act_clks = CW'(5); rec_clks = CW'(3); end
      endcase
    end
  end
endmodule

// File: rtl/mst_phase_seq.sv
module mst_phase_seq
  import mst_pkg::*;
#(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] act_clks,
  input  logic [CW-1:0] rec_clks,
  input  logic          rdy,
  output logic          ph_idle,
  output logic          ph_act,
  output logic          act_end,
  output logic          done
);
  phase_e        phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] rec_q, rec_d;
  logic          done_q, done_d;
  logic          cnt_en, rec_en;

  // next-state
  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    rec_d   = rec_q;
    cnt_en  = 1'b0;
    rec_en  = 1'b0;
    done_d  = 1'b0;
    act_end = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (start) begin
          phase_d = PH_ACT;
          cnt_d   = act_clks - CW'(1);
          rec_d   = rec_clks;
          cnt_en  = 1'b1;
          rec_en  = 1'b1;
        end
      end
      PH_ACT: begin
        if (cnt_q != '0) begin
          cnt_d  = cnt_q - CW'(1);
          cnt_en = 1'b1;
        end else if (rdy) begin
          act_end = 1'b1;
          phase_d = PH_REC;
          // the done/idle clock is the final recovery clock
          cnt_d   = rec_q - CW'(MIN_CLKS);
          cnt_en  = 1'b1;
        end
      end
      PH_REC: begin
        if (cnt_q != '0) begin
          cnt_d  = cnt_q - CW'(1);
          cnt_en = 1'b1;
        end else begin
          phase_d = PH_IDLE;
          done_d  = 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      rec_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      done_q  <= done_d;
      if (cnt_en) cnt_q <= cnt_d;
      if (rec_en) rec_q <= rec_d;
    end
  end

  assign ph_idle = (phase_q == PH_IDLE);
  assign ph_act  = (phase_q == PH_ACT);
  assign done    = done_q;
endmodule

// File: rtl/mst_strobe_timer.sv
module mst_strobe_timer
  import mst_pkg::*;
#(
  parameter int unsigned AW = 24,
  parameter int unsigned DW = 16,
  parameter int unsigned CW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  logic [CODE_W-1:0] speed_code,
  output logic              req_ready,
  input  logic              mem_ready,
  input  logic [DW-1:0]     bus_rdata,
  output logic              memr_n,
  output logic              memw_n,
  output logic [AW-1:0]     bus_addr,
  output logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     rd_data,
  output logic              done
);
  logic          rst_s1, rst_s2;
  logic [CW-1:0] act_clks, rec_clks;
  logic          ph_idle, ph_act, act_end;
  logic          accept, cap_en;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          wr_q;

  // reset: asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  mst_speed_decode #(.CW(CW)) dec_i (
    .code     (speed_code),
    .act_clks (act_clks),
    .rec_clks (rec_clks)
  );

  assign accept = req_valid && ph_idle;
  assign cap_en = act_end && !wr_q;

  mst_phase_seq #(.CW(CW)) seq_i (
    .clk      (clk),
    .rst_n    (rst_s2),
    .start    (accept),
    .act_clks (act_clks),
    .rec_clks (rec_clks),
    .rdy      (mem_ready),
    .ph_idle  (ph_idle),
    .ph_act   (ph_act),
    .act_end  (act_end),
    .done     (done)
  );

  always_ff @(posedge clk or negedge rst_s2) begin
    if (!rst_s2) begin
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        wr_q    <= req_write;
      end
      if (cap_en) rdata_q <= bus_rdata;
    end
  end

  assign req_ready = ph_idle;
  assign memr_n    = !(ph_act && !wr_q);
  assign memw_n    = !(ph_act && wr_q);
  assign bus_addr  = addr_q;
  assign bus_wdata = wdata_q;
  assign rd_data   = rdata_q;
endmodule

// File: rtl/mst_strobe_timer_chk.sv
module mst_strobe_timer_chk #(
  parameter int unsigned AW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          memr_n,
  input logic          memw_n,
  input logic          mem_ready,
  input logic          done,
  input logic          req_ready,
  input logic [AW-1:0] bus_addr
);
  logic quiet;
  assign quiet = memr_n && memw_n;

  a_r2_excl_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    !(!memr_n && !memw_n));

  a_r2_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!quiet && $past(!quiet)) |-> $stable(bus_addr));

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> quiet);

  a_r6_min_active: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(quiet) |=> !quiet);

  a_r6_min_recovery: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(quiet) |=> quiet);

  a_r8_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!quiet && !mem_ready) |=> !quiet);

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_done_ready: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (req_ready && quiet));
endmodule

bind mst_strobe_timer mst_strobe_timer_chk #(.AW(AW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .memr_n    (memr_n),
  .memw_n    (memw_n),
  .mem_ready (mem_ready),
  .done      (done),
  .req_ready (req_ready),
  .bus_addr  (bus_addr)
);

// File: tb/mst_strobe_timer_tb_top.sv
`timescale 1ns/1ps
module mst_strobe_timer_tb_top;
  localparam int unsigned AW = 24;
  localparam int unsigned DW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic [7:0]    speed_code;
  logic          req_ready, mem_ready;
  logic [DW-1:0] bus_rdata;
  logic          memr_n, memw_n;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, rd_data;
  logic          done;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  mst_strobe_timer #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .speed_code(speed_code),
    .req_ready(req_ready), .mem_ready(mem_ready), .bus_rdata(bus_rdata),
    .memr_n(memr_n), .memw_n(memw_n), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rd_data(rd_data), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One beat: measures pulse and recovery lengths at falling edges.
  task automatic run_beat(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic [7:0] c, input int exp_act, input int exp_rec,
                          input int hold_n, input string tag);
    int na = 0;
    int nr = 0;
    bit dir_ok = 1'b1;
    bit addr_ok = 1'b1;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; speed_code = c;
    if (hold_n > 0) mem_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    while ((wr ? memw_n : memr_n) == 1'b0) begin
      na++;
      if ((wr ? memr_n : memw_n) != 1'b1) dir_ok = 1'b0;
      if (bus_addr != a || (wr && bus_wdata != d)) addr_ok = 1'b0;
      bus_rdata = DW'(16'hA000 + na);
      if (hold_n > 0 && na == hold_n) mem_ready = 1'b1;
      @(negedge clk);
    end
    forever begin
      nr++;
      if (done || nr > 40) break;
      @(negedge clk);
    end
    mem_ready = 1'b1;
    chk(na == exp_act, {tag, " pulse clocks"}, na, exp_act);
    chk(nr == exp_rec, {tag, " recovery clocks"}, nr, exp_rec);
    chk(dir_ok && addr_ok, {"R2 ", tag, " direction/address"}, int'(dir_ok & addr_ok), 1);
    if (!wr)
      chk(rd_data == DW'(16'hA000 + exp_act), {"R9 ", tag, " read capture"},
          int'(rd_data), int'(DW'(16'hA000 + exp_act)));
  endtask

  task automatic t_reset;
    chk(memr_n && memw_n && !done && req_ready, "R1 reset state",
        int'({memr_n, memw_n, done, req_ready}), 4'b1101);
  endtask

  task automatic t_standard;
    run_beat(1'b0, 24'h000100, 16'h0000, 8'd0, 5, 3, 0, "R3 code0 rd");
    run_beat(1'b1, 24'h000104, 16'h1234, 8'd1, 3, 3, 0, "R3 code1 wr");
    run_beat(1'b0, 24'h000108, 16'h0000, 8'd2, 2, 3, 0, "R3 code2 rd");
    run_beat(1'b1, 24'h00010C, 16'h5678, 8'd3, 2, 2, 0, "R3 code3 wr");
    run_beat(1'b0, 24'h000110, 16'h0000, 8'd4, 4, 3, 0, "R3 code4 rd");
  endtask

  task automatic t_slow_custom;
    run_beat(1'b0, 24'h0A0000, 16'h0, 8'hFF, 9, 3, 0, "R4 code255");
    run_beat(1'b0, 24'h0A0002, 16'h0, 8'hA2, 4, 2, 0, "R5 code A2");
    run_beat(1'b1, 24'h0A0004, 16'hBEEF, 8'hB5, 6, 5, 0, "R5 code B5");
    run_beat(1'b0, 24'h0A0006, 16'h0, 8'h81, 2, 2, 0, "R6 code 81 floor");
    run_beat(1'b1, 24'h0A0008, 16'hCAFE, 8'h88, 2, 2, 0, "R6 code 88 floor");
  endtask

  task automatic t_undefined;
    run_beat(1'b0, 24'h0B0000, 16'h0, 8'd7, 5, 3, 0, "R7 code7");
    run_beat(1'b1, 24'h0B0004, 16'h0F0F, 8'd100, 5, 3, 0, "R7 code100");
  endtask

  task automatic t_wait;
    run_beat(1'b0, 24'h0C0000, 16'h0, 8'd3, 5, 2, 5, "R8 stretch to 5");
    run_beat(1'b0, 24'h0C0004, 16'h0, 8'd3, 2, 2, 2, "R8 release on last count");
    run_beat(1'b0, 24'h0C0008, 16'h0, 8'd0, 5, 3, 3, "R8 early low ignored");
  endtask

  task automatic t_hold_rdata;
    logic [DW-1:0] keep;
    run_beat(1'b0, 24'h0D0000, 16'h0, 8'd1, 3, 3, 0, "R9 hold beat");
    keep = rd_data;
    bus_rdata = 16'h5A5A;
    @(negedge clk);
    @(negedge clk);
    chk(rd_data == keep, "R9 rd_data held after beat", int'(rd_data), int'(keep));
    run_beat(1'b1, 24'h0D0004, 16'h7777, 8'd3, 2, 2, 0, "R9 write beat");
    chk(rd_data == keep, "R9 rd_data kept over write", int'(rd_data), int'(keep));
  endtask

  task automatic t_back_to_back;
    int l1 = 0;
    int h1 = 0;
    int l2 = 0;
    int guard = 0;
    bit pair_ok = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 24'h0E0000; speed_code = 8'd3;
    while (memr_n && guard < 10) begin guard++; @(negedge clk); end
    while (!memr_n) begin l1++; @(negedge clk); end
    while (memr_n && h1 < 20) begin
      h1++;
      if (done && req_ready) pair_ok = 1'b1;
      @(negedge clk);
    end
    while (!memr_n) begin
      l2++;
      req_valid = 1'b0;
      @(negedge clk);
    end
    chk(l1 == 2, "R10 first pulse", l1, 2);
    chk(h1 == 2, "R10 gap equals recovery", h1, 2);
    chk(l2 == 2, "R10 second pulse", l2, 2);
    chk(pair_ok, "R10 done with req_ready", int'(pair_ok), 1);
    guard = 0;
    while (!done && guard < 20) begin guard++; @(negedge clk); end
    @(negedge clk);
    @(negedge clk);
    chk(memr_n && memw_n, "R10 no third beat", int'({memr_n, memw_n}), 3);
  endtask

  task automatic t_ignore_busy;
    int guard = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 24'h000123; speed_code = 8'd0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 24'h000777;
    @(negedge clk);
    req_valid = 1'b0;
    chk(bus_addr == 24'h000123, "R11 address kept", int'(bus_addr), 24'h000123);
    chk(!memr_n && memw_n, "R11 direction kept", int'({memr_n, memw_n}), 2'b01);
    while (!done && guard < 20) begin guard++; @(negedge clk); end
    @(negedge clk);
    @(negedge clk);
    chk(memr_n && memw_n && req_ready, "R11 no extra beat",
        int'({memr_n, memw_n, req_ready}), 3'b111);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL R0 watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    speed_code = 8'd0; mem_ready = 1'b1; bus_rdata = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_standard();
    t_slow_custom();
    t_undefined();
    t_wait();
    t_hold_rdata();
    t_back_to_back();
    t_ignore_busy();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule